// File: doc/BRIEF.md
# Response Legality Checker

This block sits behind the packet parser of a serial-link endpoint and judges each received response against the request that is still waiting for it. When a request leaves the endpoint, the issuing logic records it in the checker's tag table under its transaction ID. It records whether the request was a read or a write that asks for a reply, and for a read the number of bytes it expects back. Each response header that arrives is matched by its target ID against that table. It is then checked for a legal status code, a transaction type that fits the request kind, and a payload whose presence and length fit the request.

The checker is a small two-state machine. In `IDLE` it holds `rsp_ready` high and takes one parsed header per handshake. The transition `ACCEPT` (valid and ready both high) moves it to `JUDGE`. For that one cycle `verdict_valid` is high and `verdict_illegal` gives the result. The transition `RETIRE` leaves `JUDGE` unconditionally back to `IDLE`. On that edge the looked-up tag entry is freed and, if the verdict was illegal, the error capture register is updated. The first illegal response latches its type, status and ID. Any later illegal response only sets a sticky overflow flag until `cap_clear` is pulsed.

Top module: `rsp_legality_chk`

## Requirements
- R1: After reset `rsp_ready` is 1, `verdict_valid` is 0, `cap_valid` is 0 and `cap_overflow` is 0.
- R2: A header is taken only on a clock edge where `rsp_valid` and `rsp_ready` are both 1. `verdict_valid` is 1 during exactly the next cycle, and `rsp_ready` is 0 in that cycle, so a header held valid is taken once per two cycles.
- R3: For a matched ID, a status other than 4'b0000 (done) or 4'b0111 (error) makes the verdict illegal, whatever the request kind.
- R4: A reply to a write-with-reply request is illegal if `rsp_has_data` is 1 or `rsp_bytes` is non-zero.
- R5: A reply to a write-with-reply request is illegal unless its type field is 4'b0000 (reply without data). Type 4'b1000 (reply with data) is illegal here even when no bytes arrive.
- R6: A reply to a read is illegal if `rsp_has_data` is 0, or if its type field is anything other than 4'b1000.
- R7: A reply to a read is illegal if `rsp_bytes` differs from the byte count recorded for that read.
- R8: A response whose target ID has no recorded outstanding request is illegal.
- R9: The table entry for the judged ID is freed at the end of the verdict cycle, whether the verdict was legal or illegal. A repeated reply with that ID is then judged as unmatched. A new record written on the same edge for that ID takes priority over the release.
- R10: On an illegal verdict while `cap_valid` is 0, the type, status and ID are captured and `cap_valid` becomes 1. While `cap_valid` stays 1, the captured fields do not change.
- R11: An illegal verdict while `cap_valid` is 1 sets `cap_overflow`, which stays set. A `cap_clear` pulse clears both `cap_valid` and `cap_overflow`. An illegal verdict on the same edge as the clear is captured as a new first error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_rec_valid | input | 1 | Record an outstanding request this cycle |
| req_rec_tid | input | TID_W | Transaction ID of the recorded request |
| req_rec_is_read | input | 1 | 1 = read, 0 = write with reply |
| req_rec_bytes | input | BYTES_W | Expected read byte count |
| rsp_valid | input | 1 | Parsed response header present |
| rsp_ready | output | 1 | Checker can take a header |
| rsp_ttype | input | 4 | Response transaction type |
| rsp_status | input | 4 | Response status |
| rsp_tid | input | TID_W | Target transaction ID |
| rsp_has_data | input | 1 | Payload present flag |
| rsp_bytes | input | BYTES_W | Payload byte count |
| verdict_valid | output | 1 | Verdict cycle |
| verdict_illegal | output | 1 | 1 = response illegal |
| cap_clear | input | 1 | Clear the capture register |
| cap_valid | output | 1 | Capture register holds an error |
| cap_overflow | output | 1 | More errors after the captured one |
| cap_ttype | output | 4 | Captured type |
| cap_status | output | 4 | Captured status |
| cap_tid | output | TID_W | Captured ID |

## Verification
A state register stuck in or skipping `JUDGE` shows up in the same cycle. `rsp_ready` and `verdict_valid` either both disagree with the two-cycle rhythm of the model or a verdict goes missing. A tag entry that is wrong, or left unreleased, changes the verdict of the next response with that ID. That verdict appears one cycle after its handshake, and a repeated-ID reply exposes a missed release at once. A capture register that drops or rewrites its contents differs from the model on the edge after the offending verdict, because the bench compares every capture output on every cycle.

// File: rtl/rsp_chk_pkg.sv
package rsp_chk_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_JUDGE = 1'b1
    } chk_state_e;

    localparam logic [3:0] TT_RSP_NODATA = 4'b0000;
    localparam logic [3:0] TT_RSP_DATA   = 4'b1000;
    localparam logic [3:0] STS_DONE      = 4'b0000;
    localparam logic [3:0] STS_ERROR     = 4'b0111;

endpackage

// File: rtl/rsp_req_table.sv
module rsp_req_table #(
    parameter int NUM_TAGS = 16,
    parameter int TID_W    = 4,
    parameter int BYTES_W  = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_en,
    input  logic [TID_W-1:0]   set_id,
    input  logic               set_is_read,
    input  logic [BYTES_W-1:0] set_bytes,
    input  logic               rel_en,
    input  logic [TID_W-1:0]   rel_id,
    input  logic [TID_W-1:0]   lk_id,
    output logic               lk_hit,
    output logic               lk_is_read,
    output logic [BYTES_W-1:0] lk_bytes
);

    logic [NUM_TAGS-1:0] ent_vld;
    logic [NUM_TAGS-1:0] ent_rd;
    logic [BYTES_W-1:0]  ent_bytes [NUM_TAGS];

    for (genvar gi = 0; gi < NUM_TAGS; gi++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_vld[gi]   <= 1'b0;
                ent_rd[gi]    <= 1'b0;
                ent_bytes[gi] <= '0;
            end else if (set_en && set_id == TID_W'(gi)) begin
                ent_vld[gi]   <= 1'b1;
                ent_rd[gi]    <= set_is_read;
                ent_bytes[gi] <= set_bytes;
            end else if (rel_en && rel_id == TID_W'(gi)) begin
                ent_vld[gi]   <= 1'b0;
            end
        end
    end

    always_comb begin
        lk_hit     = 1'b0;
        lk_is_read = 1'b0;
        lk_bytes   = '0;
        if (int'(lk_id) < NUM_TAGS) begin
            lk_hit     = ent_vld[lk_id];
            lk_is_read = ent_rd[lk_id];
            lk_bytes   = ent_bytes[lk_id];
        end
    end

    // R9: a released entry is gone on the next cycle unless re-recorded
    p_release_frees_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_en && !(set_en && set_id == rel_id) && int'(rel_id) < NUM_TAGS)
            |=> !ent_vld[$past(rel_id)]);

endmodule

// File: rtl/rsp_rule_eval.sv
module rsp_rule_eval
    import rsp_chk_pkg::*;
#(
    parameter int BYTES_W = 9
) (
    input  logic               hit,
    input  logic               is_read,
    input  logic [BYTES_W-1:0] exp_bytes,
    input  logic [3:0]         ttype,
    input  logic [3:0]         status,
    input  logic               has_data,
    input  logic [BYTES_W-1:0] bytes,
    output logic               illegal
);

    logic status_bad;
    logic read_bad;
    logic write_bad;

    always_comb begin
        status_bad = (status != STS_DONE) && (status != STS_ERROR);
        read_bad   = (ttype != TT_RSP_DATA) || !has_data || (bytes != exp_bytes);
        write_bad  = (ttype != TT_RSP_NODATA) || has_data || (bytes != '0);
        if (!hit) begin
            illegal = 1'b1;
        end else begin
            illegal = status_bad || (is_read ? read_bad : write_bad);
        end
    end

endmodule

// File: rtl/rsp_err_capture.sv
module rsp_err_capture #(
    parameter int TID_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err,
    input  logic [3:0]       err_ttype,
    input  logic [3:0]       err_status,
    input  logic [TID_W-1:0] err_tid,
    input  logic             clear,
    output logic             cap_valid,
    output logic             cap_overflow,
    output logic [3:0]       cap_ttype,
    output logic [3:0]       cap_status,
    output logic [TID_W-1:0] cap_tid
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_valid    <= 1'b0;
            cap_overflow <= 1'b0;
            cap_ttype    <= '0;
            cap_status   <= '0;
            cap_tid      <= '0;
        end else begin
            if (clear) begin
                cap_valid    <= 1'b0;
                cap_overflow <= 1'b0;
            end
            if (err) begin
                if (!cap_valid || clear) begin
                    cap_valid  <= 1'b1;
                    cap_ttype  <= err_ttype;
                    cap_status <= err_status;
                    cap_tid    <= err_tid;
                end else begin
                    cap_overflow <= 1'b1;
                end
            end
        end
    end

    // R10: held contents never change while valid and not cleared
    p_capture_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && !clear) |=> (cap_valid && $stable(cap_ttype)
                                   && $stable(cap_status) && $stable(cap_tid)));

    // R11: overflow only rises on top of an existing capture
    p_ovf_after_capture_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_overflow) |-> $past(cap_valid));

endmodule

// File: rtl/rsp_legality_chk.sv
module rsp_legality_chk
    import rsp_chk_pkg::*;
#(
    parameter int NUM_TAGS = 16,
    parameter int TID_W    = 4,
    parameter int BYTES_W  = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_rec_valid,
    input  logic [TID_W-1:0]   req_rec_tid,
    input  logic               req_rec_is_read,
    input  logic [BYTES_W-1:0] req_rec_bytes,
    input  logic               rsp_valid,
    output logic               rsp_ready,
    input  logic [3:0]         rsp_ttype,
    input  logic [3:0]         rsp_status,
    input  logic [TID_W-1:0]   rsp_tid,
    input  logic               rsp_has_data,
    input  logic [BYTES_W-1:0] rsp_bytes,
    output logic               verdict_valid,
    output logic               verdict_illegal,
    input  logic               cap_clear,
    output logic               cap_valid,
    output logic               cap_overflow,
    output logic [3:0]         cap_ttype,
    output logic [3:0]         cap_status,
    output logic [TID_W-1:0]   cap_tid
);

    chk_state_e         state_q;
    chk_state_e         state_d;
    logic               accept;
    logic [3:0]         hdr_ttype;
    logic [3:0]         hdr_status;
    logic [TID_W-1:0]   hdr_tid;
    logic               hdr_has_data;
    logic [BYTES_W-1:0] hdr_bytes;
    logic               tab_hit;
    logic               tab_is_read;
    logic [BYTES_W-1:0] tab_bytes;
    logic               rule_illegal;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: ACCEPT (IDLE->JUDGE), RETIRE (JUDGE->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_JUDGE;
            ST_JUDGE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rsp_ready       = 1'b0;
        verdict_valid   = 1'b0;
        unique case (state_q)
            ST_IDLE:  rsp_ready     = 1'b1;
            ST_JUDGE: verdict_valid = 1'b1;
            default:  rsp_ready     = 1'b0;
        endcase
        verdict_illegal = verdict_valid && rule_illegal;
    end

    assign accept = rsp_valid && rsp_ready;

    // header holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_ttype    <= '0;
            hdr_status   <= '0;
            hdr_tid      <= '0;
            hdr_has_data <= 1'b0;
            hdr_bytes    <= '0;
        end else if (accept) begin
            hdr_ttype    <= rsp_ttype;
            hdr_status   <= rsp_status;
            hdr_tid      <= rsp_tid;
            hdr_has_data <= rsp_has_data;
            hdr_bytes    <= rsp_bytes;
        end
    end

    rsp_req_table #(
        .NUM_TAGS (NUM_TAGS),
        .TID_W    (TID_W),
        .BYTES_W  (BYTES_W)
    ) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_en      (req_rec_valid),
        .set_id      (req_rec_tid),
        .set_is_read (req_rec_is_read),
        .set_bytes   (req_rec_bytes),
        .rel_en      (verdict_valid),
        .rel_id      (hdr_tid),
        .lk_id       (hdr_tid),
        .lk_hit      (tab_hit),
        .lk_is_read  (tab_is_read),
        .lk_bytes    (tab_bytes)
    );

    rsp_rule_eval #(
        .BYTES_W (BYTES_W)
    ) u_rules (
        .hit       (tab_hit),
        .is_read   (tab_is_read),
        .exp_bytes (tab_bytes),
        .ttype     (hdr_ttype),
        .status    (hdr_status),
        .has_data  (hdr_has_data),
        .bytes     (hdr_bytes),
        .illegal   (rule_illegal)
    );

    rsp_err_capture #(
        .TID_W (TID_W)
    ) u_capture (
        .clk          (clk),
        .rst_n        (rst_n),
        .err          (verdict_illegal),
        .err_ttype    (hdr_ttype),
        .err_status   (hdr_status),
        .err_tid      (hdr_tid),
        .clear        (cap_clear),
        .cap_valid    (cap_valid),
        .cap_overflow (cap_overflow),
        .cap_ttype    (cap_ttype),
        .cap_status   (cap_status),
        .cap_tid      (cap_tid)
    );

    // R2: a verdict follows every handshake in the next cycle
    p_verdict_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready) |=> verdict_valid);

    // R2: verdicts never come back to back
    p_verdict_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_valid |=> !verdict_valid);

    // R8: an ID missing from the table always yields an illegal verdict
    p_unmatched_illegal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict_valid && !tab_hit) |-> verdict_illegal);

endmodule

// File: tb/rsp_legality_chk_tb.sv
module rsp_legality_chk_tb;

    localparam int NT = 16;
    localparam int TW = 4;
    localparam int BW = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_rec_valid = 1'b0;
    logic [TW-1:0] req_rec_tid = '0;
    logic          req_rec_is_read = 1'b0;
    logic [BW-1:0] req_rec_bytes = '0;
    logic          rsp_valid = 1'b0;
    logic          rsp_ready;
    logic [3:0]    rsp_ttype = '0;
    logic [3:0]    rsp_status = '0;
    logic [TW-1:0] rsp_tid = '0;
    logic          rsp_has_data = 1'b0;
    logic [BW-1:0] rsp_bytes = '0;
    logic          verdict_valid;
    logic          verdict_illegal;
    logic          cap_clear = 1'b0;
    logic          cap_valid;
    logic          cap_overflow;
    logic [3:0]    cap_ttype;
    logic [3:0]    cap_status;
    logic [TW-1:0] cap_tid;

    int n_checks = 0;
    int n_bad    = 0;
    int cycles   = 0;

    always #2.5 clk = ~clk;

    rsp_legality_chk #(.NUM_TAGS(NT), .TID_W(TW), .BYTES_W(BW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_rec_valid(req_rec_valid), .req_rec_tid(req_rec_tid),
        .req_rec_is_read(req_rec_is_read), .req_rec_bytes(req_rec_bytes),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_ttype(rsp_ttype), .rsp_status(rsp_status), .rsp_tid(rsp_tid),
        .rsp_has_data(rsp_has_data), .rsp_bytes(rsp_bytes),
        .verdict_valid(verdict_valid), .verdict_illegal(verdict_illegal),
        .cap_clear(cap_clear), .cap_valid(cap_valid), .cap_overflow(cap_overflow),
        .cap_ttype(cap_ttype), .cap_status(cap_status), .cap_tid(cap_tid)
    );

    // ---------------- behavioural reference model ----------------
    bit          m_open  [NT];
    bit          m_read  [NT];
    int          m_size  [NT];
    bit          m_busy = 0;
    int          m_tt, m_st, m_id, m_bytes;
    bit          m_data;
    bit          m_cv = 0, m_ov = 0;
    int          m_ctt = 0, m_cst = 0, m_cid = 0;

    function automatic bit ref_illegal();
        bit st_ok;
        st_ok = (m_st == 0) || (m_st == 7);
        if (!m_open[m_id]) return 1;
        if (m_read[m_id])
            return !st_ok || m_tt != 8 || !m_data || m_bytes != m_size[m_id];
        return !st_ok || m_tt != 0 || m_data || m_bytes != 0;
    endfunction

    function automatic string ref_tag();
        if (!m_open[m_id]) return "R8";
        if (!((m_st == 0) || (m_st == 7))) return "R3";
        if (m_read[m_id]) begin
            if (m_bytes != m_size[m_id] && m_data && m_tt == 8) return "R7";
            return "R6";
        end
        if (m_data || m_bytes != 0) return "R4";
        return "R5";
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_open[i]) m_open[i] = 0;
            m_busy = 0; m_cv = 0; m_ov = 0;
        end else begin
            bit err;
            bit was_busy;
            err = m_busy && ref_illegal();
            was_busy = m_busy;
            if (m_busy) begin
                m_open[m_id] = 0;
                m_busy = 0;
            end
            if (cap_clear) begin m_cv = 0; m_ov = 0; end
            if (err) begin
                if (!m_cv) begin
                    m_cv = 1; m_ctt = m_tt; m_cst = m_st; m_cid = m_id;
                end else m_ov = 1;
            end
            if (req_rec_valid) begin
                m_open[req_rec_tid] = 1;
                m_read[req_rec_tid] = req_rec_is_read;
                m_size[req_rec_tid] = int'(req_rec_bytes);
            end
            if (!was_busy && rsp_valid) begin
                m_busy = 1; m_tt = rsp_ttype; m_st = rsp_status; m_id = rsp_tid;
                m_data = rsp_has_data; m_bytes = int'(rsp_bytes);
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check(rsp_ready == !m_busy, "R2", rsp_ready, !m_busy);
            check(verdict_valid == m_busy, "R2", verdict_valid, m_busy);
            if (m_busy)
                check(verdict_illegal == ref_illegal(), ref_tag(), verdict_illegal, ref_illegal());
            check(cap_valid == m_cv, "R10", cap_valid, m_cv);
            check(cap_overflow == m_ov, "R11", cap_overflow, m_ov);
            if (m_cv) begin
                check(int'(cap_ttype) == m_ctt, "R10", cap_ttype, m_ctt);
                check(int'(cap_status) == m_cst, "R10", cap_status, m_cst);
                check(int'(cap_tid) == m_cid, "R10", cap_tid, m_cid);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic rec(input int id, input bit rd, input int nb);
        req_rec_valid = 1; req_rec_tid = TW'(id); req_rec_is_read = rd; req_rec_bytes = BW'(nb);
        @(negedge clk);
        req_rec_valid = 0;
    endtask

    task automatic send(input int tt, input int st, input int id, input bit dat, input int nb,
                        input int hold);
        rsp_valid = 1; rsp_ttype = 4'(tt); rsp_status = 4'(st); rsp_tid = TW'(id);
        rsp_has_data = dat; rsp_bytes = BW'(nb);
        repeat (hold) @(negedge clk);
        rsp_valid = 0;
        @(negedge clk);
    endtask

    task automatic pulse_clear();
        cap_clear = 1;
        @(negedge clk);
        cap_clear = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(rsp_ready == 1, "R1", rsp_ready, 1);
        check(verdict_valid == 0, "R1", verdict_valid, 0);
        check(cap_valid == 0 && cap_overflow == 0, "R1", {cap_valid, cap_overflow}, 0);

        // legal read and legal writes
        rec(3, 1, 8);  send(8, 0, 3, 1, 8, 1);
        rec(5, 0, 0);  send(0, 0, 5, 0, 0, 1);
        rec(6, 0, 0);  send(0, 7, 6, 0, 0, 1);
        check(cap_valid == 0, "R3", cap_valid, 0);
        // R3 bad status on a read: first error captured (R10)
        rec(2, 1, 4);  send(8, 3, 2, 1, 4, 1);
        check(cap_valid == 1 && cap_tid == 2, "R10", cap_tid, 2);
        // R4 write reply carrying payload -> overflow (R11)
        rec(7, 0, 0);  send(0, 0, 7, 1, 4, 1);
        check(cap_overflow == 1 && cap_tid == 2, "R11", cap_overflow, 1);
        pulse_clear();
        // R4 byte count without flag
        rec(7, 0, 0);  send(0, 0, 7, 0, 2, 1);
        pulse_clear();
        // R5 write reply with data type but no bytes
        rec(8, 0, 0);  send(8, 0, 8, 0, 0, 1);
        check(cap_ttype == 8 && cap_tid == 8, "R5", cap_ttype, 8);
        pulse_clear();
        // R6 read reply without payload, then with no-data type
        rec(9, 1, 16); send(8, 0, 9, 0, 16, 1);
        pulse_clear();
        rec(9, 1, 16); send(0, 0, 9, 1, 16, 1);
        pulse_clear();
        // R7 size mismatch, then correct size
        rec(10, 1, 8); send(8, 0, 10, 1, 16, 1);
        pulse_clear();
        rec(10, 1, 8); send(8, 7, 10, 1, 8, 1);
        check(cap_valid == 0, "R7", cap_valid, 0);
        // R8 unmatched ID
        send(0, 0, 12, 0, 0, 1);
        check(cap_valid == 1 && cap_tid == 12, "R8", cap_tid, 12);
        pulse_clear();
        // R9 repeated reply after a legal one is unmatched
        rec(11, 0, 0); send(0, 0, 11, 0, 0, 1);
        send(0, 0, 11, 0, 0, 1);
        check(cap_valid == 1 && cap_tid == 11, "R9", cap_tid, 11);
        // R9 record on the same edge as the release wins
        rec(1, 0, 0);
        rsp_valid = 1; rsp_ttype = 0; rsp_status = 0; rsp_tid = 1; rsp_has_data = 0; rsp_bytes = 0;
        @(negedge clk);
        rsp_valid = 0;
        rec(1, 1, 4);
        send(8, 0, 1, 1, 4, 1);
        // R2 header held valid: taken every other cycle
        rec(4, 0, 0); rec(13, 0, 0);
        send(0, 0, 4, 0, 0, 3);
        // R11 clear on the same edge as a new error
        rec(14, 1, 4);
        rsp_valid = 1; rsp_ttype = 0; rsp_status = 0; rsp_tid = 14; rsp_has_data = 1; rsp_bytes = 4;
        @(negedge clk);
        rsp_valid = 0; cap_clear = 1;
        @(negedge clk);
        cap_clear = 0;
        check(cap_valid == 1 && cap_tid == 14 && cap_overflow == 0, "R11", cap_tid, 14);
        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 20000);
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

endmodule